// File: doc/BRIEF.md
# Super I/O Plug-and-Play Configuration Port

This block is the configuration front end of a multi-function I/O controller. The host reaches it through two byte-wide ports: an index port and a data port. Configuration is locked after reset. The host unlocks it by writing the enter key to the index port twice in a row, and locks it again by writing the exit key. While unlocked, the host writes an index to the index port and then reads or writes the selected register through the data port.

A logical-device number register picks one of several register banks. The default build has three banks: two serial ports at device numbers 1 and 2, and a power-management device at 0x0A. Each bank holds an activation bit, two 16-bit I/O bases and an IRQ number, and drives them out as live settings to the function cores. The power-management bank also holds a status flag. A single-cycle event input sets the flag, and software clears it by writing a one to it.

The unlock logic is a three-state machine:
- LOCKED goes to KEY1 on an index write of 0x87.
- KEY1 goes to OPEN on an index write of 0x87.
- KEY1 goes back to LOCKED on an index write of any other value.
- OPEN goes to LOCKED on an index write of 0xAA.
- Every other case holds the current state.

Top module: `sio_cfg_port`

## Requirements
- R1: Two consecutive index-port writes of 0x87 set `cfg_mode` high after the second write's clock edge.
- R2: An index-port write of any other value after a single 0x87 returns the machine to the locked state. Two new 0x87 writes are then needed to unlock.
- R3: An index-port write of 0xAA while unlocked clears `cfg_mode` after that edge.
- R4: While locked, data-port writes change no register, and reads of either port return 0xFF.
- R5: While unlocked, index-port writes other than 0xAA load the index. Reading the index port returns the index, and data accesses target the register the index selects. `port_sel` is 0 for the index port and 1 for the data port.
- R6: Register 0x07 holds the device number and reads back what was written. Registers 0x30 and above go to the bank whose device number matches it. With an unmatched number, writes change nothing and reads return 0x00.
- R7: Bit 0 of register 0x30 is the bank's activation enable and appears on `dev_active`. The register reads back with bits 7:1 as 0.
- R8: Registers 0x60/0x61 are the high/low bytes of the first base, and 0x62/0x63 of the second base. Each base appears as `{high, low}` on its 16-bit output slice.
- R9: In serial-port banks, bits 2:0 of the first base always read as 0, which keeps the window aligned to 8 bytes. In other banks all base bits are stored.
- R10: Register 0x70 holds the bank's IRQ number, which appears on `dev_irq`.
- R11: A `pme_event` pulse sets `pme_status`. Writing a value with bit 7 set to register 0xFB of device 0x0A clears it, and writing bit 7 as 0 has no effect. A set and a clear in the same cycle leave the flag set. Register 0xFB reads the flag in bit 7.
- R12: After reset the block is locked and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Read byte, combinational while `rd_en` is high, 0x00 otherwise |
| pme_event | input | 1 | Single-cycle power event that sets the status flag |
| cfg_mode | output | 1 | High while configuration is unlocked |
| dev_active | output | NDEV | Activation enable of each bank |
| dev_base0 | output | 16*NDEV | First I/O base of each bank, bank i at [16i+15:16i] |
| dev_base1 | output | 16*NDEV | Second I/O base of each bank |
| dev_irq | output | 8*NDEV | IRQ number of each bank |
| pme_status | output | 1 | Power-management status flag |

Bank order on the vector outputs: slot 0 is device 1, slot 1 is device 2, slot 2 is device 0x0A.

## Verification
The assertions check these rules on every cycle:
- the machine unlocks only right after an index write of 0x87;
- a broken key sequence or the exit key locks it;
- locked reads return 0xFF;
- serial base alignment holds;
- bank settings stay put without a strobe;
- an event always leaves the status flag set.

Only the bench scenarios can show that values land in the right bank through the device number, that unmatched numbers are harmless, that the index survives a lock/unlock cycle, and how the flag resolves a same-cycle set and clear.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    typedef enum logic [1:0] {
        S_LOCKED = 2'd0,
        S_KEY1   = 2'd1,
        S_OPEN   = 2'd2
    } key_state_e;

    localparam logic [7:0] KEY_ENTER = 8'h87;
    localparam logic [7:0] KEY_EXIT  = 8'hAA;

    localparam logic [7:0] IDX_LDN    = 8'h07;
    localparam logic [7:0] IDX_BANK0  = 8'h30;
    localparam logic [7:0] IDX_ACT    = 8'h30;
    localparam logic [7:0] IDX_B0_HI  = 8'h60;
    localparam logic [7:0] IDX_B0_LO  = 8'h61;
    localparam logic [7:0] IDX_B1_HI  = 8'h62;
    localparam logic [7:0] IDX_B1_LO  = 8'h63;
    localparam logic [7:0] IDX_IRQ    = 8'h70;
    localparam logic [7:0] IDX_PMSTAT = 8'hFB;

    localparam int PMSTAT_BIT = 7;

endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       cfg_open
);

    key_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_LOCKED: if (idx_wr && wdata == KEY_ENTER) state_d = S_KEY1;
            S_KEY1:   if (idx_wr) state_d = (wdata == KEY_ENTER) ? S_OPEN : S_LOCKED;
            S_OPEN:   if (idx_wr && wdata == KEY_EXIT) state_d = S_LOCKED;
            default:  state_d = S_LOCKED;
        endcase
    end

    always_comb begin
        cfg_open = (state_q == S_OPEN);
    end

    // R1: unlocking is always the result of an enter-key write
    p_enter_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(idx_wr && wdata == KEY_ENTER));

    // R2: a wrong byte after the first key leaves the block locked
    p_break_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_KEY1 && idx_wr && wdata != KEY_ENTER) |=> !cfg_open);

    // R3: exit key locks
    p_exit_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && idx_wr && wdata == KEY_EXIT) |=> !cfg_open);

endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
    import sio_cfg_pkg::*;
#(
    parameter bit IS_UART = 1'b0,
    parameter bit HAS_PME = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bank_wr,
    input  logic [7:0]  reg_idx,
    input  logic [7:0]  wdata,
    input  logic        pme_event,
    output logic        act,
    output logic [15:0] base0,
    output logic [15:0] base1,
    output logic [7:0]  irq,
    output logic        pme_flag,
    output logic [7:0]  rd_val
);

    localparam logic [7:0] B0_LO_MASK = IS_UART ? 8'hF8 : 8'hFF;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act   <= 1'b0;
            base0 <= '0;
            base1 <= '0;
            irq   <= '0;
        end else if (bank_wr) begin
            case (reg_idx)
                IDX_ACT:   act          <= wdata[0];
                IDX_B0_HI: base0[15:8]  <= wdata;
                IDX_B0_LO: base0[7:0]   <= wdata & B0_LO_MASK;
                IDX_B1_HI: base1[15:8]  <= wdata;
                IDX_B1_LO: base1[7:0]   <= wdata;
                IDX_IRQ:   irq          <= wdata;
                default: ;
            endcase
        end
    end

    generate
        if (HAS_PME) begin : g_pme
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pme_flag <= 1'b0;
                else if (pme_event)
                    pme_flag <= 1'b1;
                else if (bank_wr && reg_idx == IDX_PMSTAT && wdata[PMSTAT_BIT])
                    pme_flag <= 1'b0;
            end

            // R11: an event always leaves the flag set
            p_pme_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
                pme_event |=> pme_flag);
        end else begin : g_no_pme
            assign pme_flag = 1'b0;
        end

        if (IS_UART) begin : g_align
            // R9: serial window stays 8-byte aligned
            p_base_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
                base0[2:0] == 3'b000);
        end
    endgenerate

    always_comb begin
        rd_val = 8'h00;
        case (reg_idx)
            IDX_ACT:    rd_val = {7'b0, act};
            IDX_B0_HI:  rd_val = base0[15:8];
            IDX_B0_LO:  rd_val = base0[7:0];
            IDX_B1_HI:  rd_val = base1[15:8];
            IDX_B1_LO:  rd_val = base1[7:0];
            IDX_IRQ:    rd_val = irq;
            IDX_PMSTAT: rd_val = {pme_flag, 7'b0};
            default:    rd_val = 8'h00;
        endcase
    end

    // R7: settings hold without a bank write
    p_hold_act_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_wr |=> $stable(act) && $stable(irq) && $stable(base0));

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int                NDEV      = 3,
    parameter logic [NDEV*8-1:0] DEV_NUMS  = {8'h0A, 8'h02, 8'h01},
    parameter logic [NDEV-1:0]   UART_MASK = 3'b011,
    parameter logic [NDEV-1:0]   PME_MASK  = 3'b100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic               port_sel,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    input  logic               pme_event,
    output logic               cfg_mode,
    output logic [NDEV-1:0]    dev_active,
    output logic [16*NDEV-1:0] dev_base0,
    output logic [16*NDEV-1:0] dev_base1,
    output logic [8*NDEV-1:0]  dev_irq,
    output logic               pme_status
);

    localparam int DW = 8;

    logic            idx_wr, dat_wr, cfg_open;
    logic [DW-1:0]   index_q, ldn_q;
    logic [NDEV-1:0] hit, bank_wr, pme_vec;
    logic [DW-1:0]   bank_rd [NDEV];

    assign idx_wr = wr_en && !port_sel;
    assign dat_wr = wr_en && port_sel && cfg_open;

    sio_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (wdata),
        .cfg_open (cfg_open)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0;
            ldn_q   <= '0;
        end else begin
            if (idx_wr && cfg_open && wdata != KEY_EXIT) index_q <= wdata;
            if (dat_wr && index_q == IDX_LDN) ldn_q <= wdata;
        end
    end

    generate
        for (genvar i = 0; i < NDEV; i++) begin : g_bank
            assign hit[i]     = (ldn_q == DEV_NUMS[8*i +: 8]);
            assign bank_wr[i] = dat_wr && hit[i] && (index_q >= IDX_BANK0);

            sio_dev_bank #(
                .IS_UART (UART_MASK[i]),
                .HAS_PME (PME_MASK[i])
            ) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .bank_wr   (bank_wr[i]),
                .reg_idx   (index_q),
                .wdata     (wdata),
                .pme_event (pme_event),
                .act       (dev_active[i]),
                .base0     (dev_base0[16*i +: 16]),
                .base1     (dev_base1[16*i +: 16]),
                .irq       (dev_irq[8*i +: 8]),
                .pme_flag  (pme_vec[i]),
                .rd_val    (bank_rd[i])
            );
        end
    endgenerate

    always_comb begin
        cfg_mode   = cfg_open;
        pme_status = |pme_vec;
    end

    always_comb begin
        logic [DW-1:0] sel_val;
        sel_val = '0;
        for (int i = 0; i < NDEV; i++)
            if (hit[i]) sel_val = bank_rd[i];
        if (!rd_en)
            rdata = 8'h00;
        else if (!cfg_open)
            rdata = 8'hFF;
        else if (!port_sel)
            rdata = index_q;
        else if (index_q == IDX_LDN)
            rdata = ldn_q;
        else if (index_q < IDX_BANK0)
            rdata = 8'h00;
        else
            rdata = sel_val;
    end

    // R4: locked reads return all ones
    p_locked_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !cfg_mode) |-> rdata == 8'hFF);

    // R4: no bank write strobe while locked
    p_locked_nowr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |-> bank_wr == '0);

    // R6: at most one bank matches the device number
    p_one_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: tb/test_sio_cfg_port.sv
module test_sio_cfg_port;

    localparam int NDEV = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0, rd_en = 1'b0, port_sel = 1'b0;
    logic [7:0]         wdata = 8'h00;
    logic [7:0]         rdata;
    logic               pme_event = 1'b0;
    logic               cfg_mode;
    logic [NDEV-1:0]    dev_active;
    logic [16*NDEV-1:0] dev_base0, dev_base1;
    logic [8*NDEV-1:0]  dev_irq;
    logic               pme_status;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;

    rd_item_t sb_q[$];

    always #2.5 clk = ~clk;

    sio_cfg_port i_sio_cfg_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .port_sel   (port_sel),
        .wdata      (wdata),
        .rdata      (rdata),
        .pme_event  (pme_event),
        .cfg_mode   (cfg_mode),
        .dev_active (dev_active),
        .dev_base0  (dev_base0),
        .dev_base1  (dev_base1),
        .dev_irq    (dev_irq),
        .pme_status (pme_status)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_idx(input logic [7:0] v);
        wr_en = 1'b1; port_sel = 1'b0; wdata = v;
        step();
        wr_en = 1'b0;
    endtask

    task automatic wr_dat(input logic [7:0] v);
        wr_en = 1'b1; port_sel = 1'b1; wdata = v;
        step();
        wr_en = 1'b0;
    endtask

    task automatic set_reg(input logic [7:0] idx, input logic [7:0] v);
        wr_idx(idx);
        wr_dat(v);
    endtask

    task automatic rd_exp(input logic psel, input logic [7:0] exp, input string tag);
        rd_item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        rd_en = 1'b1; port_sel = psel;
        step();
        rd_en = 1'b0;
    endtask

    task automatic unlock();
        wr_idx(8'h87);
        wr_idx(8'h87);
    endtask

    // monitor: compares reads mid-cycle against queued expectations
    always @(negedge clk) begin
        if (rd_en) begin
            checks++;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL read without expectation actual=%h expected=none", rdata);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                if (rdata !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, rdata, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();

        // R12 reset state
        chk("R12 cfg_mode", cfg_mode, 0);
        chk("R12 active", dev_active, 0);
        chk("R12 base0", dev_base0[31:0], 0);
        chk("R12 pme", pme_status, 0);
        rd_exp(1'b1, 8'hFF, "R4 locked data read");

        // R4 locked data write ignored
        wr_idx(8'h07);
        wr_dat(8'h01);
        // R2 broken sequence
        wr_idx(8'h87);
        wr_idx(8'h55);
        chk("R2 locked after break", cfg_mode, 0);
        wr_idx(8'h87);
        chk("R2 one key not enough", cfg_mode, 0);
        wr_idx(8'h87);
        chk("R1 unlocked", cfg_mode, 1);

        // R5 index readback, R6 device number
        wr_idx(8'h07);
        rd_exp(1'b0, 8'h07, "R5 index readback");
        rd_exp(1'b1, 8'h00, "R4 locked write ignored ldn");
        wr_dat(8'h01);
        rd_exp(1'b1, 8'h01, "R6 ldn readback");

        // R7 activation
        set_reg(8'h30, 8'hFF);
        chk("R7 active", dev_active, 3'b001);
        rd_exp(1'b1, 8'h01, "R7 act readback");

        // R8 / R9 first base, serial alignment
        set_reg(8'h60, 8'h03);
        set_reg(8'h61, 8'hFF);
        chk("R9 base0 uart", dev_base0[15:0], 16'h03F8);
        rd_exp(1'b1, 8'hF8, "R9 low byte readback");
        set_reg(8'h62, 8'h12);
        set_reg(8'h63, 8'h34);
        chk("R8 base1", dev_base1[15:0], 16'h1234);

        // R10 irq
        set_reg(8'h70, 8'h04);
        chk("R10 irq", dev_irq[7:0], 8'h04);

        // R6 second bank
        set_reg(8'h07, 8'h02);
        set_reg(8'h30, 8'h01);
        set_reg(8'h60, 8'h02);
        set_reg(8'h61, 8'hF8);
        chk("R6 active both", dev_active, 3'b011);
        chk("R6 base0 slot1", dev_base0[31:16], 16'h02F8);
        chk("R6 slot0 irq kept", dev_irq[7:0], 8'h04);

        // R9 non-serial bank keeps low bits
        set_reg(8'h07, 8'h0A);
        set_reg(8'h60, 8'h01);
        set_reg(8'h61, 8'h07);
        chk("R9 base0 pm bank", dev_base0[47:32], 16'h0107);

        // R6 unmatched device
        set_reg(8'h07, 8'h05);
        set_reg(8'h30, 8'h01);
        chk("R6 unmatched write", dev_active, 3'b011);
        rd_exp(1'b1, 8'h00, "R6 unmatched read");

        // R11 status flag
        pme_event = 1'b1;
        step();
        pme_event = 1'b0;
        chk("R11 set", pme_status, 1);
        set_reg(8'h07, 8'h0A);
        wr_idx(8'hFB);
        rd_exp(1'b1, 8'h80, "R11 readback");
        wr_dat(8'h7F);
        chk("R11 zero write no effect", pme_status, 1);
        wr_dat(8'h80);
        chk("R11 cleared", pme_status, 0);
        pme_event = 1'b1;
        wr_dat(8'h80);
        pme_event = 1'b0;
        chk("R11 set wins", pme_status, 1);
        wr_dat(8'hFF);
        chk("R11 cleared again", pme_status, 0);

        // R3 exit, R4 locked behaviour
        set_reg(8'h07, 8'h01);
        wr_idx(8'h30);
        wr_idx(8'hAA);
        chk("R3 locked", cfg_mode, 0);
        rd_exp(1'b1, 8'hFF, "R4 locked data read");
        rd_exp(1'b0, 8'hFF, "R4 locked index read");
        wr_dat(8'h00);
        chk("R4 locked write ignored", dev_active, 3'b011);
        unlock();
        rd_exp(1'b0, 8'h30, "R5 index kept");
        rd_exp(1'b1, 8'h01, "R4 act unchanged");

        step();
        if (sb_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard actual=%0d expected=0", sb_q.size());
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule